// File: doc/BRIEF.md
# List Path Metric Calculator

This block performs the metric-update step of list decoding with two surviving paths. Each cycle that `in_valid` is high it takes the soft value of the current bit (`in_llr`) and the metrics of the two surviving paths (`in_pm0`, `in_pm1`). It extends each survivor with bit value 0 and with bit value 1, which gives four candidate children. It adds a penalty term to each child's parent metric and returns two children. Each returned child carries its metric, the index of its parent and the bit value it appended.

The penalty term is log(1+e^x), replaced by a three-segment line. The argument x is the bit LLR for a 0 extension and its negation for a 1 extension. One negation unit, two penalty units and four saturating adders build the candidates. A ranking network then keeps the two candidates with the highest metrics. When `in_frozen` is set, only 0 extensions are legal, and the block returns both parents extended with 0. The result is registered, so the block forms one stage of a reconciliation pipeline.

Top module: `lpm_calc`

## Requirements
- R1: Candidate metrics are formed as parent metric plus penalty. A bit-0 child uses penalty g(in_llr) and a bit-1 child uses g(-in_llr). Parent 0 takes in_pm0 and parent 1 takes in_pm1.
- R2: The penalty g(x) is counted in metric LSBs, where one metric LSB is half of one LLR unit. g(x) is 0 for x <= -1, 1 for x = 0, and 2x for x >= 1. Negating an in_llr of -128 yields +128 without wrapping.
- R3: A candidate metric whose true sum exceeds 1023 is reported as 1023.
- R4: With in_frozen low, the best slot holds the candidate with the highest metric and the next slot holds the second highest. The two slots name different (parent, bit) pairs.
- R5: Candidates with equal metrics rank lower parent index first, then bit value 0 before bit value 1.
- R6: With in_frozen high, the best slot is parent 0 with bit 0 and the next slot is parent 1 with bit 0. Each metric is its parent metric plus g(in_llr), whatever the metric order.
- R7: out_valid is high exactly in the cycle after a cycle with in_valid high. The output fields change only on such an update and hold otherwise.
- R8: After reset, out_valid is low and every output field is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input set is valid this cycle |
| in_llr | input | 8 | Signed bit LLR, integer units |
| in_pm0 | input | 10 | Metric of survivor 0 |
| in_pm1 | input | 10 | Metric of survivor 1 |
| in_frozen | input | 1 | Bit is frozen; only 0 extensions allowed |
| out_valid | output | 1 | Output set is valid |
| out_best_pm | output | 10 | Metric of first returned child |
| out_best_par | output | 1 | Parent index of first child |
| out_best_bit | output | 1 | Appended bit of first child |
| out_next_pm | output | 10 | Metric of second returned child |
| out_next_par | output | 1 | Parent index of second child |
| out_next_bit | output | 1 | Appended bit of second child |

## Verification
A fault in the penalty segments, the negation or the saturation shows up as a wrong metric in the very next output cycle. A fault in the ranking network shows up one cycle after the input that exposes it, as a swapped slot or a wrong (parent, bit) tag. Equal-metric inputs and frozen bits are needed to expose ordering faults, because plain inputs give distinct metrics. Because the output register loads only on valid input, a capture fault appears as output fields that change while in_valid is low.

// File: rtl/lpm_pkg.sv
// Shared defaults and types for the list path metric calculator.
// Assumes a list of two survivors, hence four candidates.
package lpm_pkg;
    localparam int LPM_LLR_W  = 8;
    localparam int LPM_PM_W   = 10;
    localparam int LPM_LIST   = 2;
    localparam int LPM_NCAND  = 2 * LPM_LIST;
    localparam int LPM_IDX_W  = $clog2(LPM_NCAND);

    // Candidate tag: which survivor was extended and with which bit.
    typedef struct packed {
        logic par;
        logic bval;
    } lpm_tag_t;
endpackage

// File: rtl/lpm_penalty.sv
// Three-segment penalty unit approximating log(1+e^x).
// Output is in metric LSBs (half an LLR unit): 0, 1 or 2x.
// Assumes x is signed, one bit wider than the raw LLR.
module lpm_penalty #(
    parameter int LLR_W = 8
) (
    input  logic signed [LLR_W:0] x,
    output logic        [LLR_W:0] pen
);
    // Select the segment from the sign and zero test of x.
    always_comb begin
        if (x[LLR_W])
            pen = '0;
        else if (x == '0)
            pen = {{LLR_W{1'b0}}, 1'b1};
        else
            pen = {x[LLR_W-1:0], 1'b0};
    end
endmodule

// File: rtl/lpm_sat_add.sv
// Unsigned adder that clamps its result to the metric range.
// Assumes both operands are unsigned.
module lpm_sat_add #(
    parameter int PM_W  = 10,
    parameter int PEN_W = 9
) (
    input  logic [PM_W-1:0]  a,
    input  logic [PEN_W-1:0] b,
    output logic [PM_W-1:0]  y
);
    localparam int SUM_W = ((PM_W > PEN_W) ? PM_W : PEN_W) + 1;

    logic [SUM_W-1:0] sum;

    // Add at full width, then clamp to all ones when the range is exceeded.
    always_comb begin
        sum = SUM_W'(a) + SUM_W'(b);
        if (sum > SUM_W'({PM_W{1'b1}}))
            y = '1;
        else
            y = sum[PM_W-1:0];
    end
endmodule

// File: rtl/lpm_top2.sv
// Ranks candidates and returns the indices of the highest and
// second highest metric. An equal metric ranks the lower index
// first, so index order encodes the tie policy (parent, then bit).
module lpm_top2 #(
    parameter int PM_W  = 10,
    parameter int NCAND = 4,
    parameter int IDX_W = 2
) (
    input  logic [NCAND-1:0][PM_W-1:0] m,
    output logic [IDX_W-1:0]           idx_best,
    output logic [IDX_W-1:0]           idx_next
);
    logic [NCAND-1:0][NCAND-1:0] beats;   // beats[i][j]: j outranks i
    logic [NCAND-1:0][IDX_W-1:0] rank;

    for (genvar i = 0; i < NCAND; i++) begin : g_row
        for (genvar j = 0; j < NCAND; j++) begin : g_col
            if (i == j) begin : g_self
                assign beats[i][j] = 1'b0;
            end else if (j < i) begin : g_lo
                assign beats[i][j] = (m[j] >= m[i]);
            end else begin : g_hi
                assign beats[i][j] = (m[j] > m[i]);
            end
        end
        // Rank of candidate i is the number of candidates above it.
        always_comb begin
            rank[i] = '0;
            for (int j = 0; j < NCAND; j++)
                rank[i] = rank[i] + IDX_W'(beats[i][j]);
        end
    end

    // Pick the candidates holding rank 0 and rank 1.
    always_comb begin
        idx_best = '0;
        idx_next = '0;
        for (int i = 0; i < NCAND; i++) begin
            if (rank[i] == IDX_W'(0)) idx_best = IDX_W'(i);
            if (rank[i] == IDX_W'(1)) idx_next = IDX_W'(i);
        end
    end
endmodule

// File: rtl/lpm_calc.sv
// List path metric calculator for two survivors.
// Builds four child metrics (survivor x bit), keeps the best two,
// or both bit-0 children when the bit is frozen, and registers the
// result one cycle after in_valid. Candidate index = {parent, bit}.
module lpm_calc
    import lpm_pkg::*;
#(
    parameter int LLR_W = LPM_LLR_W,
    parameter int PM_W  = LPM_PM_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [LLR_W-1:0] in_llr,
    input  logic        [PM_W-1:0]  in_pm0,
    input  logic        [PM_W-1:0]  in_pm1,
    input  logic                    in_frozen,
    output logic                    out_valid,
    output logic        [PM_W-1:0]  out_best_pm,
    output logic                    out_best_par,
    output logic                    out_best_bit,
    output logic        [PM_W-1:0]  out_next_pm,
    output logic                    out_next_par,
    output logic                    out_next_bit
);
    localparam int PEN_W = LLR_W + 1;

    logic signed [LLR_W:0]           llr_pos;
    logic signed [LLR_W:0]           llr_neg;
    logic [1:0][PEN_W-1:0]           pen;      // indexed by bit value
    logic [LPM_NCAND-1:0][PM_W-1:0]  cand;
    logic [LPM_IDX_W-1:0]            idx_best;
    logic [LPM_IDX_W-1:0]            idx_next;
    lpm_tag_t                        tag_best;
    lpm_tag_t                        tag_next;

    // Widen the LLR by one bit and negate it for the bit-1 branch.
    always_comb begin
        llr_pos = {in_llr[LLR_W-1], in_llr};
        llr_neg = -llr_pos;
    end

    lpm_penalty #(.LLR_W(LLR_W)) u_pen0 (.x(llr_pos), .pen(pen[0]));
    lpm_penalty #(.LLR_W(LLR_W)) u_pen1 (.x(llr_neg), .pen(pen[1]));

    for (genvar c = 0; c < LPM_NCAND; c++) begin : g_add
        lpm_sat_add #(.PM_W(PM_W), .PEN_W(PEN_W)) u_add (
            .a ((c / 2 == 0) ? in_pm0 : in_pm1),
            .b (pen[c % 2]),
            .y (cand[c])
        );
    end

    lpm_top2 #(.PM_W(PM_W), .NCAND(LPM_NCAND), .IDX_W(LPM_IDX_W)) u_sel (
        .m        (cand),
        .idx_best (idx_best),
        .idx_next (idx_next)
    );

    // A frozen bit overrides the ranking with both bit-0 children.
    always_comb begin
        if (in_frozen) begin
            tag_best = '{par: 1'b0, bval: 1'b0};
            tag_next = '{par: 1'b1, bval: 1'b0};
        end else begin
            tag_best = idx_best;
            tag_next = idx_next;
        end
    end

    // Capture the selected children on valid input; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_best_pm  <= '0;
            out_best_par <= 1'b0;
            out_best_bit <= 1'b0;
            out_next_pm  <= '0;
            out_next_par <= 1'b0;
            out_next_bit <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_best_pm  <= cand[tag_best];
                out_best_par <= tag_best.par;
                out_best_bit <= tag_best.bval;
                out_next_pm  <= cand[tag_next];
                out_next_par <= tag_next.par;
                out_next_bit <= tag_next.bval;
            end
        end
    end
endmodule

// File: rtl/lpm_calc_chk.sv
// Property checker for lpm_calc, attached with bind below.
// Assumes the synchronous active-low reset of the host module.
module lpm_calc_chk #(
    parameter int PM_W = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            in_frozen,
    input logic            out_valid,
    input logic [PM_W-1:0] out_best_pm,
    input logic            out_best_par,
    input logic            out_best_bit,
    input logic [PM_W-1:0] out_next_pm,
    input logic            out_next_par,
    input logic            out_next_bit
);
    // R7
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R7
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R7
    hold_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_best_pm) && $stable(out_next_pm)
                       && $stable(out_best_par) && $stable(out_next_par)
                       && $stable(out_best_bit) && $stable(out_next_bit)));

    // R4
    order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_frozen) |=> (out_best_pm >= out_next_pm));

    // R4
    distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_frozen) |=>
            ({out_best_par, out_best_bit} != {out_next_par, out_next_bit}));

    // R6
    frozen_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_frozen) |=>
            (!out_best_par && out_next_par && !out_best_bit && !out_next_bit));
endmodule

bind lpm_calc lpm_calc_chk #(.PM_W(PM_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_frozen    (in_frozen),
    .out_valid    (out_valid),
    .out_best_pm  (out_best_pm),
    .out_best_par (out_best_par),
    .out_best_bit (out_best_bit),
    .out_next_pm  (out_next_pm),
    .out_next_par (out_next_par),
    .out_next_bit (out_next_bit)
);

// File: tb/lpm_calc_tb.sv
// Bench for lpm_calc: a vector table walked by one loop, then
// directed checks of reset, latency and holding.
module lpm_calc_tb;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic signed [7:0] in_llr = '0;
    logic [9:0]        in_pm0 = '0;
    logic [9:0]        in_pm1 = '0;
    logic              in_frozen = 1'b0;
    logic              out_valid;
    logic [9:0]        out_best_pm;
    logic              out_best_par;
    logic              out_best_bit;
    logic [9:0]        out_next_pm;
    logic              out_next_par;
    logic              out_next_bit;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    lpm_calc u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_llr(in_llr),
        .in_pm0(in_pm0), .in_pm1(in_pm1), .in_frozen(in_frozen),
        .out_valid(out_valid),
        .out_best_pm(out_best_pm), .out_best_par(out_best_par),
        .out_best_bit(out_best_bit),
        .out_next_pm(out_next_pm), .out_next_par(out_next_par),
        .out_next_bit(out_next_bit)
    );

    // Fields: llr(8) pm0(10) pm1(10) frozen(1) bpm(10) bpar bbit npm(10) npar nbit
    localparam int NVEC = 10;
    localparam logic [52:0] VECS [NVEC] = '{
        // R1 R4: positive LLR, distinct metrics
        {8'd5,   10'd100, 10'd50,  1'b0, 10'd110,  1'b0, 1'b0, 10'd100,  1'b0, 1'b1},
        // R1 R2: negative LLR favours the bit-1 children
        {8'hFD,  10'd20,  10'd40,  1'b0, 10'd46,   1'b1, 1'b1, 10'd40,   1'b1, 1'b0},
        // R2 R5: zero LLR, bit tie inside parent 1
        {8'd0,   10'd7,   10'd9,   1'b0, 10'd10,   1'b1, 1'b0, 10'd10,   1'b1, 1'b1},
        // R5: parent tie resolved by lower parent
        {8'd4,   10'd30,  10'd30,  1'b0, 10'd38,   1'b0, 1'b0, 10'd38,   1'b1, 1'b0},
        // R2 R3: negation of -128 and clamp
        {8'h80,  10'd1000,10'd0,   1'b0, 10'd1023, 1'b0, 1'b1, 10'd1000, 1'b0, 1'b0},
        // R3 R5: two clamped candidates tie
        {8'd127, 10'd900, 10'd950, 1'b0, 10'd1023, 1'b0, 1'b0, 10'd1023, 1'b1, 1'b0},
        // R6: frozen, parent order kept though parent 1 is larger
        {8'hFE,  10'd50,  10'd80,  1'b1, 10'd50,   1'b0, 1'b0, 10'd80,   1'b1, 1'b0},
        // R6: frozen with positive LLR
        {8'd6,   10'd10,  10'd5,   1'b1, 10'd22,   1'b0, 1'b0, 10'd17,   1'b1, 1'b0},
        // R2: segment edge x = 1
        {8'd1,   10'd0,   10'd0,   1'b0, 10'd2,    1'b0, 1'b0, 10'd2,    1'b1, 1'b0},
        // R2: segment edge x = -1
        {8'hFF,  10'd3,   10'd0,   1'b0, 10'd5,    1'b0, 1'b1, 10'd3,    1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one input set for one cycle; return at the negedge after capture.
    task automatic drive(input logic [7:0] llr, input logic [9:0] p0,
                         input logic [9:0] p1, input logic fr);
        @(negedge clk);
        in_llr = llr; in_pm0 = p0; in_pm1 = p1; in_frozen = fr;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 valid", 32'(out_valid), 0);
        check("R8 best_pm", 32'(out_best_pm), 0);
        check("R8 next_pm", 32'(out_next_pm), 0);
        check("R8 tags", 32'({out_best_par, out_best_bit, out_next_par, out_next_bit}), 0);
        rst_n = 1'b1;

        for (int v = 0; v < NVEC; v++) begin
            logic [52:0] w;
            w = VECS[v];
            drive(w[52:45], w[44:35], w[34:25], w[24]);
            check($sformatf("R1 R4 R6 vec%0d valid", v), 32'(out_valid), 1);
            check($sformatf("R1 R4 R6 vec%0d best_pm", v), 32'(out_best_pm), 32'(w[23:14]));
            check($sformatf("R4 R5 vec%0d best_tag", v),
                  32'({out_best_par, out_best_bit}), 32'(w[13:12]));
            check($sformatf("R1 R4 R6 vec%0d next_pm", v), 32'(out_next_pm), 32'(w[11:2]));
            check($sformatf("R4 R5 vec%0d next_tag", v),
                  32'({out_next_par, out_next_bit}), 32'(w[1:0]));
        end

        // R7: valid drops one cycle after in_valid drops
        @(negedge clk);
        check("R7 valid low", 32'(out_valid), 0);

        // R7: changing inputs without in_valid leaves outputs unchanged
        in_llr = 8'd50; in_pm0 = 10'd500; in_pm1 = 10'd600; in_frozen = 1'b0;
        repeat (2) @(negedge clk);
        check("R7 hold best_pm", 32'(out_best_pm), 3'd5);
        check("R7 hold next_pm", 32'(out_next_pm), 3'd3);
        check("R7 hold valid", 32'(out_valid), 0);

        // R7: back-to-back valid cycles
        @(negedge clk);
        in_llr = 8'd2; in_pm0 = 10'd0; in_pm1 = 10'd1; in_valid = 1'b1;
        @(negedge clk);
        check("R7 b2b first", 32'(out_best_pm), 5);
        in_llr = 8'hFE;
        @(negedge clk);
        in_valid = 1'b0;
        check("R7 b2b second", 32'(out_best_pm), 5);
        check("R7 b2b second tag", 32'({out_best_par, out_best_bit}), 3);
        check("R7 b2b valid", 32'(out_valid), 1);

        // R8: reset mid-run clears the outputs
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 re-reset pm", 32'(out_best_pm), 0);
        check("R8 re-reset valid", 32'(out_valid), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule